// File: doc/BRIEF.md
# NAND ECC Syndrome Decoder

This block judges one 256-byte flash sector after a read. It takes two 24-bit Hamming-style check codes: the one stored in the spare area and read back, and the one recomputed over the data just read. It forms their bitwise difference, called the syndrome, and sorts it into one of four outcomes. The sector can be clean. It can hold one flipped data bit, which can be repaired. The stored code itself can have one flipped bit, in which case the data is intact. Otherwise the error is beyond repair.

For a repairable data error the decoder gives the byte offset inside the sector, the bit number inside that byte and a one-hot flip mask. Logic outside the block uses these to XOR the faulty byte in its own buffer. A mode input selects which of the two line-parity bytes of each code comes first. This lets one decoder serve both common byte orders of the check code. The result is registered and appears one cycle after the strobe that presented the codes.

Top module: `ecc_syn_decoder`

## Requirements
- R1: Each code is packed as first byte in bits 7:0, second byte in bits 15:8 and third byte in bits 23:16. With `swap_order_i`=0 the XOR of the first bytes forms line syndrome H and the XOR of the second bytes forms line syndrome L. With `swap_order_i`=1 the first bytes form L and the second bytes form H. The third bytes always form the column syndrome C.
- R2: If the two codes are equal, `status_o` is 2'b00 (clean).
- R3: `status_o` is 2'b01 (data bit repaired) when, in each of H and L, bits 2k+1 and 2k differ for all k in 0..3, and in C bits 2k+1 and 2k differ for k in 1..3. C bits 1:0 have no effect on this test.
- R4: With status 2'b01, `byte_loc_o` equals {H[7],H[5],H[3],H[1],L[7],L[5],L[3],L[1]}, MSB first.
- R5: With status 2'b01, `bit_loc_o` equals {C[7],C[5],C[3]}, MSB first, and `flip_mask_o` equals 8'b1 shifted left by `bit_loc_o`.
- R6: A nonzero syndrome that fails the R3 test and has exactly one of its 24 bits set gives `status_o` 2'b10 (code-area bit error).
- R7: Every other nonzero syndrome gives `status_o` 2'b11 (uncorrectable).
- R8: Results are captured on the clock edge where `strobe_i` is high. They appear on the outputs in the next cycle, with `valid_o` high for exactly that one cycle. Without a strobe the outputs hold their values.
- R9: Whenever `status_o` is not 2'b01, `byte_loc_o`, `bit_loc_o` and `flip_mask_o` are zero.
- R10: While `rst_n` is low, `valid_o` is 0, `status_o` is 2'b00 and all location outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Codes are valid this cycle; decode them |
| swap_order_i | input | 1 | Byte order of the two line-parity bytes (R1) |
| code_rd_i | input | 24 | Check code read from the flash spare area |
| code_calc_i | input | 24 | Check code recomputed over the data |
| valid_o | output | 1 | One-cycle pulse: new result present |
| status_o | output | 2 | 00 clean, 01 data bit repaired, 10 code-area bit, 11 uncorrectable |
| byte_loc_o | output | 8 | Byte offset of the faulty data bit |
| bit_loc_o | output | 3 | Bit number of the faulty data bit |
| flip_mask_o | output | 8 | One-hot mask to XOR into the faulty byte |

## Verification
The assertions assume that `code_rd_i`, `code_calc_i` and `swap_order_i` are stable and known whenever `strobe_i` is high. The weight-based properties read the raw XOR of those ports on the strobe edge. The bench drives every input only on the falling edge, so each strobe edge sees settled codes. Its syndromes are built from a chosen location, from a chosen weight, or from random bits, which reaches all four outcomes in both byte orders.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;

  // Decoder verdict; the encoding is visible on the status port.
  typedef enum logic [1:0] {
    ST_CLEAN    = 2'b00,
    ST_DATA_FIX = 2'b01,
    ST_CODE_BIT = 2'b10,
    ST_FATAL    = 2'b11
  } ecc_status_e;

  // Number of bytes in one check code.
  localparam int CODE_BYTES = 3;

endpackage

// File: rtl/ecc_syn_former.sv
// Forms the three syndrome bytes and routes the two line bytes by mode.
module ecc_syn_former #(
  parameter int BYTE_W = 8,
  parameter int CODE_W = ecc_syn_pkg::CODE_BYTES * BYTE_W
) (
  input  logic [CODE_W-1:0] code_rd,
  input  logic [CODE_W-1:0] code_calc,
  input  logic              swap_order,
  output logic [BYTE_W-1:0] syn_lo,
  output logic [BYTE_W-1:0] syn_hi,
  output logic [BYTE_W-1:0] syn_col
);

  logic [BYTE_W-1:0] diff [ecc_syn_pkg::CODE_BYTES];

  generate
    for (genvar g = 0; g < ecc_syn_pkg::CODE_BYTES; g++) begin : g_byte
      assign diff[g] = code_rd[g*BYTE_W +: BYTE_W] ^ code_calc[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_comb begin
    if (swap_order) begin
      syn_lo = diff[0];
      syn_hi = diff[1];
    end else begin
      syn_lo = diff[1];
      syn_hi = diff[0];
    end
    syn_col = diff[2];
  end

endmodule

// File: rtl/ecc_syn_classifier.sv
// Sorts a syndrome into one of four verdicts.
module ecc_syn_classifier #(
  parameter int BYTE_W = 8,
  parameter int PAIRS  = BYTE_W / 2
) (
  input  logic [BYTE_W-1:0]        syn_lo,
  input  logic [BYTE_W-1:0]        syn_hi,
  input  logic [BYTE_W-1:0]        syn_col,
  output ecc_syn_pkg::ecc_status_e status,
  output logic                     pairs_ok,
  output logic                     syn_zero,
  output logic                     syn_single
);
  import ecc_syn_pkg::*;

  localparam int SYN_W = 3 * BYTE_W;

  logic [PAIRS-1:0] lo_split;
  logic [PAIRS-1:0] hi_split;
  logic [PAIRS-1:1] col_split;
  logic [SYN_W-1:0] syn_all;

  // Population count of the whole syndrome.
  function automatic int weight(input logic [SYN_W-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < SYN_W; i++) n += int'(v[i]);
    return n;
  endfunction

  // A true/inverted pair is valid when its two bits differ.
  function automatic logic pair_differs(input logic odd_b, input logic even_b);
    return odd_b ^ even_b;
  endfunction

  generate
    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
      assign lo_split[k] = pair_differs(syn_lo[2*k+1], syn_lo[2*k]);
      assign hi_split[k] = pair_differs(syn_hi[2*k+1], syn_hi[2*k]);
      if (k > 0) begin : g_col
        assign col_split[k] = pair_differs(syn_col[2*k+1], syn_col[2*k]);
      end
    end
  endgenerate

  assign syn_all    = {syn_col, syn_hi, syn_lo};
  assign syn_zero   = (syn_all == '0);
  assign syn_single = (weight(syn_all) == 1);
  assign pairs_ok   = (&lo_split) & (&hi_split) & (&col_split);

  always_comb begin
    if (syn_zero)        status = ST_CLEAN;
    else if (pairs_ok)   status = ST_DATA_FIX;
    else if (syn_single) status = ST_CODE_BIT;
    else                 status = ST_FATAL;
  end

endmodule

// File: rtl/ecc_syn_locator.sv
// Turns the odd syndrome bits into byte offset, bit number and flip mask.
module ecc_syn_locator #(
  parameter int PAIRS  = 4,
  parameter int OFFS_W = 2 * PAIRS,
  parameter int BITN_W = PAIRS - 1,
  parameter int MASK_W = 1 << BITN_W
) (
  input  logic              fix_en,
  input  logic [PAIRS-1:0]  hi_odd,
  input  logic [PAIRS-1:0]  lo_odd,
  input  logic [BITN_W-1:0] col_odd,
  output logic [OFFS_W-1:0] byte_loc,
  output logic [BITN_W-1:0] bit_loc,
  output logic [MASK_W-1:0] flip_mask
);

  function automatic logic [MASK_W-1:0] one_hot(input logic [BITN_W-1:0] n);
    return MASK_W'(1) << n;
  endfunction

  always_comb begin
    if (fix_en) begin
      byte_loc  = {hi_odd, lo_odd};
      bit_loc   = col_odd;
      flip_mask = one_hot(col_odd);
    end else begin
      byte_loc  = '0;
      bit_loc   = '0;
      flip_mask = '0;
    end
  end

endmodule

// File: rtl/ecc_syn_decoder.sv
// Top: syndrome forming, classification, location, one output register stage.
module ecc_syn_decoder #(
  parameter int BYTE_W = 8,
  parameter int CODE_W = ecc_syn_pkg::CODE_BYTES * BYTE_W,
  parameter int PAIRS  = BYTE_W / 2,
  parameter int OFFS_W = 2 * PAIRS,
  parameter int BITN_W = PAIRS - 1,
  parameter int MASK_W = 1 << BITN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              swap_order_i,
  input  logic [CODE_W-1:0] code_rd_i,
  input  logic [CODE_W-1:0] code_calc_i,
  output logic              valid_o,
  output logic [1:0]        status_o,
  output logic [OFFS_W-1:0] byte_loc_o,
  output logic [BITN_W-1:0] bit_loc_o,
  output logic [MASK_W-1:0] flip_mask_o
);
  import ecc_syn_pkg::*;

  // Named internal events, visible to the checker.
  logic [BYTE_W-1:0] syn_lo, syn_hi, syn_col;
  ecc_status_e       verdict;
  logic              pairs_ok, syn_zero, syn_single;
  logic [PAIRS-1:0]  hi_odd, lo_odd;
  logic [BITN_W-1:0] col_odd;
  logic [OFFS_W-1:0] byte_loc_d;
  logic [BITN_W-1:0] bit_loc_d;
  logic [MASK_W-1:0] flip_mask_d;

  ecc_syn_former #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) former_i (
    .code_rd   (code_rd_i),
    .code_calc (code_calc_i),
    .swap_order(swap_order_i),
    .syn_lo    (syn_lo),
    .syn_hi    (syn_hi),
    .syn_col   (syn_col)
  );

  ecc_syn_classifier #(.BYTE_W(BYTE_W), .PAIRS(PAIRS)) classifier_i (
    .syn_lo    (syn_lo),
    .syn_hi    (syn_hi),
    .syn_col   (syn_col),
    .status    (verdict),
    .pairs_ok  (pairs_ok),
    .syn_zero  (syn_zero),
    .syn_single(syn_single)
  );

  // Odd bit of each pair carries the location.
  generate
    for (genvar k = 0; k < PAIRS; k++) begin : g_odd
      assign hi_odd[k] = syn_hi[2*k+1];
      assign lo_odd[k] = syn_lo[2*k+1];
      if (k > 0) begin : g_col
        assign col_odd[k-1] = syn_col[2*k+1];
      end
    end
  endgenerate

  ecc_syn_locator #(.PAIRS(PAIRS), .OFFS_W(OFFS_W), .BITN_W(BITN_W), .MASK_W(MASK_W)) locator_i (
    .fix_en   (verdict == ST_DATA_FIX),
    .hi_odd   (hi_odd),
    .lo_odd   (lo_odd),
    .col_odd  (col_odd),
    .byte_loc (byte_loc_d),
    .bit_loc  (bit_loc_d),
    .flip_mask(flip_mask_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o     <= 1'b0;
      status_o    <= ST_CLEAN;
      byte_loc_o  <= '0;
      bit_loc_o   <= '0;
      flip_mask_o <= '0;
    end else begin
      valid_o <= strobe_i;
      if (strobe_i) begin
        status_o    <= verdict;
        byte_loc_o  <= byte_loc_d;
        bit_loc_o   <= bit_loc_d;
        flip_mask_o <= flip_mask_d;
      end
    end
  end

endmodule

// File: rtl/ecc_syn_decoder_chk.sv
// Temporal checks on the decoder, attached by bind.
module ecc_syn_decoder_chk #(
  parameter int CODE_W = 24,
  parameter int OFFS_W = 8,
  parameter int BITN_W = 3,
  parameter int MASK_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe_i,
  input logic [CODE_W-1:0] code_rd_i,
  input logic [CODE_W-1:0] code_calc_i,
  input logic              valid_o,
  input logic [1:0]        status_o,
  input logic [OFFS_W-1:0] byte_loc_o,
  input logic [BITN_W-1:0] bit_loc_o,
  input logic [MASK_W-1:0] flip_mask_o
);

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_i |=> valid_o);

  assert_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> !valid_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> ($stable(status_o) && $stable(byte_loc_o) && $stable(bit_loc_o) && $stable(flip_mask_o)));

  assert_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && (code_rd_i == code_calc_i)) |=> (status_o == 2'b00));

  assert_code_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && ($countones(code_rd_i ^ code_calc_i) == 1)) |=> (status_o == 2'b10));

  assert_double_fatal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && ($countones(code_rd_i ^ code_calc_i) == 2)) |=> (status_o == 2'b11));

  assert_mask_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 2'b01) |-> ($countones(flip_mask_o) == 1));

  assert_loc_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != 2'b01) |-> (byte_loc_o == '0 && bit_loc_o == '0 && flip_mask_o == '0));

endmodule

bind ecc_syn_decoder ecc_syn_decoder_chk #(
  .CODE_W(CODE_W), .OFFS_W(OFFS_W), .BITN_W(BITN_W), .MASK_W(MASK_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .strobe_i   (strobe_i),
  .code_rd_i  (code_rd_i),
  .code_calc_i(code_calc_i),
  .valid_o    (valid_o),
  .status_o   (status_o),
  .byte_loc_o (byte_loc_o),
  .bit_loc_o  (bit_loc_o),
  .flip_mask_o(flip_mask_o)
);

// File: tb/ecc_syn_decoder_tb_top.sv
`timescale 1ns/1ps
module ecc_syn_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe_i = 1'b0;
  logic        swap_order_i = 1'b0;
  logic [23:0] code_rd_i = '0;
  logic [23:0] code_calc_i = '0;
  logic        valid_o;
  logic [1:0]  status_o;
  logic [7:0]  byte_loc_o;
  logic [2:0]  bit_loc_o;
  logic [7:0]  flip_mask_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ecc_syn_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .swap_order_i(swap_order_i),
    .code_rd_i(code_rd_i), .code_calc_i(code_calc_i), .valid_o(valid_o),
    .status_o(status_o), .byte_loc_o(byte_loc_o), .bit_loc_o(bit_loc_o),
    .flip_mask_o(flip_mask_o)
  );

  // Behavioural reference: verdict from the requirement text.
  task automatic ref_decode(input logic [23:0] rd, input logic [23:0] calc, input logic sw,
                            output logic [1:0] st, output logic [7:0] by,
                            output logic [2:0] bi, output logic [7:0] mk);
    logic [23:0] x;
    logic [7:0] h, l, c;
    int ones;
    bit ok;
    x = rd ^ calc;
    h = sw ? x[15:8] : x[7:0];
    l = sw ? x[7:0]  : x[15:8];
    c = x[23:16];
    ones = $countones(x);
    ok = 1;
    for (int p = 0; p < 4; p++) begin
      if (h[2*p] == h[2*p+1]) ok = 0;
      if (l[2*p] == l[2*p+1]) ok = 0;
      if (p > 0 && c[2*p] == c[2*p+1]) ok = 0;
    end
    by = '0; bi = '0; mk = '0;
    if (ones == 0) st = 2'b00;
    else if (ok) begin
      st = 2'b01;
      by = {h[7], h[5], h[3], h[1], l[7], l[5], l[3], l[1]};
      bi = {c[7], c[5], c[3]};
      mk = 8'h01 << bi;
    end else if (ones == 1) st = 2'b10;
    else st = 2'b11;
  endtask

  // Per-clock model, compared on every falling edge.
  logic       m_valid;
  logic [1:0] m_st;
  logic [7:0] m_by, m_mk;
  logic [2:0] m_bi;

  always @(posedge clk or negedge rst_n) begin
    logic [1:0] st; logic [7:0] by, mk; logic [2:0] bi;
    if (!rst_n) begin
      m_valid <= 0; m_st <= 0; m_by <= 0; m_bi <= 0; m_mk <= 0;
    end else begin
      m_valid <= strobe_i;
      if (strobe_i) begin
        ref_decode(code_rd_i, code_calc_i, swap_order_i, st, by, bi, mk);
        m_st <= st; m_by <= by; m_bi <= bi; m_mk <= mk;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ({valid_o, status_o, byte_loc_o, bit_loc_o, flip_mask_o} !== {m_valid, m_st, m_by, m_bi, m_mk}) begin
        failures++;
        $display("FAIL R8 model: got v=%0b st=%0b by=%02h bi=%0d mk=%02h exp v=%0b st=%0b by=%02h bi=%0d mk=%02h",
                 valid_o, status_o, byte_loc_o, bit_loc_o, flip_mask_o,
                 m_valid, m_st, m_by, m_bi, m_mk);
      end
    end
  end

  // Syndrome {C,H,L} for a single data-bit error at (off, bn).
  function automatic logic [23:0] syn_for(input logic [7:0] off, input logic [2:0] bn, input logic [1:0] c_low);
    logic [7:0] h, l, c;
    h = '0; l = '0; c = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < 4) begin l[2*i+1] = off[i];   l[2*i] = ~off[i];   end
      else       begin h[2*i-7] = off[i];   h[2*i-8] = ~off[i]; end
    end
    for (int j = 0; j < 3; j++) begin c[2*j+3] = bn[j]; c[2*j+2] = ~bn[j]; end
    c[1:0] = c_low;
    return {c, h, l};
  endfunction

  // Place {C,H,L} into code byte order for a mode (R1).
  function automatic logic [23:0] place(input logic [23:0] s, input logic sw);
    return sw ? {s[23:16], s[15:8], s[7:0]} : {s[23:16], s[7:0], s[15:8]};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic run_case(input string tag, input logic [23:0] xr, input logic sw,
                          input logic [1:0] e_st, input logic [7:0] e_by, input logic [2:0] e_bi);
    logic [7:0] e_mk;
    e_mk = (e_st == 2'b01) ? (8'h01 << e_bi) : 8'h00;
    @(negedge clk);
    code_calc_i = 24'h3C96F0;
    code_rd_i = 24'h3C96F0 ^ xr;
    swap_order_i = sw;
    strobe_i = 1'b1;
    @(negedge clk);
    strobe_i = 1'b0;
    check({tag, " valid"}, 32'(valid_o), 32'd1);
    check({tag, " status"}, 32'(status_o), 32'(e_st));
    check({tag, " byte"}, 32'(byte_loc_o), 32'(e_by));
    check({tag, " bit"}, 32'(bit_loc_o), 32'(e_bi));
    check({tag, " mask"}, 32'(flip_mask_o), 32'(e_mk));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 valid", 32'(valid_o), 0);
    check("R10 status", 32'(status_o), 0);
    check("R10 mask", 32'({byte_loc_o, bit_loc_o, flip_mask_o}), 0);
    rst_n = 1'b1;

    run_case("R2 clean normal", 24'h0, 1'b0, 2'b00, 8'h00, 3'd0);
    run_case("R2 clean swap",   24'h0, 1'b1, 2'b00, 8'h00, 3'd0);
    run_case("R3 R4 R5 off00 b0",  place(syn_for(8'h00, 3'd0, 2'b00), 1'b0), 1'b0, 2'b01, 8'h00, 3'd0);
    run_case("R3 R4 R5 offFF b7",  place(syn_for(8'hFF, 3'd7, 2'b00), 1'b0), 1'b0, 2'b01, 8'hFF, 3'd7);
    run_case("R1 swap off5A b3",   place(syn_for(8'h5A, 3'd3, 2'b00), 1'b1), 1'b1, 2'b01, 8'h5A, 3'd3);
    // R1: normal-order bytes read in swapped mode: nibbles exchange
    run_case("R1 cross order",     place(syn_for(8'h5A, 3'd3, 2'b00), 1'b0), 1'b1, 2'b01, 8'hA5, 3'd3);
    run_case("R3 C low bits set",  place(syn_for(8'h81, 3'd5, 2'b11), 1'b0), 1'b0, 2'b01, 8'h81, 3'd5);
    run_case("R6 R9 bit0",  24'h000001, 1'b0, 2'b10, 8'h00, 3'd0);
    run_case("R6 R9 bit12", 24'h001000, 1'b1, 2'b10, 8'h00, 3'd0);
    run_case("R6 R9 bit23", 24'h800000, 1'b0, 2'b10, 8'h00, 3'd0);
    run_case("R7 two bits", 24'h000003, 1'b0, 2'b11, 8'h00, 3'd0);
    run_case("R7 all ones", 24'hFFFFFF, 1'b1, 2'b11, 8'h00, 3'd0);
    run_case("R7 C pair broken", place(syn_for(8'h33, 3'd2, 2'b00), 1'b0) ^ 24'h400000,
             1'b0, 2'b11, 8'h00, 3'd0);

    // R8: hold without strobe
    run_case("R8 before hold", place(syn_for(8'hC4, 3'd6, 2'b00), 1'b0), 1'b0, 2'b01, 8'hC4, 3'd6);
    @(negedge clk);
    code_rd_i = '0; code_calc_i = 24'hFFFFFF;
    @(negedge clk);
    check("R8 hold valid", 32'(valid_o), 0);
    check("R8 hold status", 32'(status_o), 32'(2'b01));
    check("R8 hold byte", 32'(byte_loc_o), 32'h C4);

    // Random mix compared against the per-clock model.
    for (int n = 0; n < 400; n++) begin
      logic [23:0] xr;
      logic sw;
      int kind;
      kind = int'($urandom_range(0, 3));
      sw = 1'($urandom);
      case (kind)
        0: xr = place(syn_for(8'($urandom), 3'($urandom), 2'($urandom)), sw);
        1: xr = 24'h1 << $urandom_range(0, 23);
        2: xr = 24'($urandom);
        default: xr = '0;
      endcase
      @(negedge clk);
      code_calc_i = 24'($urandom);
      code_rd_i = code_calc_i ^ xr;
      swap_order_i = sw;
      strobe_i = 1'($urandom_range(0, 3) != 0);
    end
    @(negedge clk);
    strobe_i = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule